// File: doc/BRIEF.md
# Half-Bridge Dead-Band Generator

This block sits between a PWM action stage and a half-bridge gate driver. It takes two raw PWM signals, A and B, and produces the two drive outputs. To leave a gap between the high-side and low-side switches, it can hold back the rising edge on one path and the falling edge on the other by a programmable number of time-base clock ticks.

Three small select fields set the switch network. The source select chooses which raw input drives each delay. The output select chooses, for each output, the delayed signal or the raw one. The polarity select can invert each delayed signal. Delay counts are in time-base ticks. The count for a wanted gap is the tick rate in MHz multiplied by the gap in microseconds. A count of zero makes that delay a plain wire. The outputs are combinational from the raw inputs and the delay state, so a later stage can register them.

Top module: `dbgen_deadband`

## Requirements
- R1: With `out_sel` = 00, `out_a` equals `raw_a` and `out_b` equals `raw_b` in every cycle, whatever `src_sel` and `pol_sel` hold.
- R2: `out_sel[1]` = 1 puts the rising-delayed path on `out_a`; 0 passes `raw_a` straight through with no inversion. `out_sel[0]` = 1 puts the falling-delayed path on `out_b`; 0 passes `raw_b` straight through with no inversion. So 01 gives raw A with delayed B, 10 gives delayed A with raw B, and 11 delays both.
- R3: `src_sel[0]` picks the rising-delay source and `src_sel[1]` picks the falling-delay source (0 = `raw_a`, 1 = `raw_b`). So 00 uses A for both, 01 uses B for rising and A for falling, 10 uses A for rising and B for falling, and 11 uses B for both.
- R4: `pol_sel[0]` = 1 inverts the delayed signal routed to `out_a`, and `pol_sel[1]` = 1 inverts the delayed signal routed to `out_b`. 10 is the active-high complementary setting. Polarity has no effect on an output that passes its raw input.
- R5: The rising-delayed signal is high only while its source is high and the source has been high at no fewer than `rise_cnt` consecutive prior enabled clock edges. It drops in the same cycle its source drops.
- R6: The falling-delayed signal is low only while its source is low and the source has been low at no fewer than `fall_cnt` consecutive prior enabled clock edges. It rises in the same cycle its source rises.
- R7: A source pulse lasting N or fewer enabled cycles, where N is the programmed count, never appears on the delayed signal. A pulse of N+1 cycles appears for exactly one cycle.
- R8: A count of zero makes that delayed signal follow its source in the same cycle.
- R9: When `tick_en` is low, a clock edge does not advance a delay's elapsed time. A source change still restarts it at that edge.
- R10: The elapsed time saturates at 2^CNT_W-1, so the largest count, once reached, keeps the delayed signal asserted while the source holds.
- R11: A low `rst_n` at a clock edge clears elapsed time on both paths. While reset is held, a path with a nonzero count stays idle: the rising-delayed path is low and the falling-delayed path is high, before polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Time-base enable; the elapsed time advances only on enabled edges |
| raw_a | input | 1 | Raw PWM A from the action stage |
| raw_b | input | 1 | Raw PWM B from the action stage |
| rise_cnt | input | CNT_W | Rising-edge delay in ticks |
| fall_cnt | input | CNT_W | Falling-edge delay in ticks |
| src_sel | input | 2 | Delay input source select |
| out_sel | input | 2 | Per-output delayed/raw select |
| pol_sel | input | 2 | Per-output inversion of the delayed path |
| out_a | output | 1 | Drive output A |
| out_b | output | 1 | Drive output B |

## Verification
Two events can land in the same cycle: a delay expiring and its source dropping. A pulse exactly one tick longer than the count should show for one cycle, and a pulse as long as the count should not show at all. The bench drives pulses of exactly N and N+1 enabled cycles, sweeps every source, output and polarity code against random A/B waveforms with gaps in the enable, and checks both outputs in every cycle against an elapsed-time model. A second overlap comes from a disabled tick that falls on the same edge as a source change. The bench judges it by requiring a full count of enabled edges after the change.

// File: rtl/dbgen_pkg.sv
// Shared constants for the dead-band generator.
// Fixes the bit positions of the three 2-bit select fields so that the
// router, the output stage and the checker decode them the same way.
package dbgen_pkg;
    // src_sel: which raw input feeds each delay (0 = A, 1 = B)
    localparam int SRC_RISE_BIT = 0;
    localparam int SRC_FALL_BIT = 1;
    // out_sel: which output takes its delayed path
    localparam int OUT_A_BIT    = 1;
    localparam int OUT_B_BIT    = 0;
    // pol_sel: which delayed path is inverted
    localparam int POL_A_BIT    = 0;
    localparam int POL_B_BIT    = 1;
    // number of delay lanes: lane 0 delays rising edges, lane 1 falling
    localparam int NUM_LANES    = 2;

    typedef enum logic [1:0] {
        OUTM_BYPASS = 2'b00,
        OUTM_B_ONLY = 2'b01,
        OUTM_A_ONLY = 2'b10,
        OUTM_BOTH   = 2'b11
    } out_mode_e;

    // Conditional inversion used by the output stage.
    function automatic logic flip_if(input logic v, input logic inv);
        return inv ? ~v : v;
    endfunction
endpackage

// File: rtl/dbgen_src_mux.sv
// Source router: chooses, for each delay lane, the raw input that feeds it.
// Assumes both raw inputs are already in the time-base clock domain.
module dbgen_src_mux
    import dbgen_pkg::*;
(
    input  logic       raw_a,
    input  logic       raw_b,
    input  logic [1:0] src_sel,
    output logic       rise_src,
    output logic       fall_src
);
    // Pick each lane's source independently from its select bit.
    always_comb begin
        rise_src = src_sel[SRC_RISE_BIT] ? raw_b : raw_a;
        fall_src = src_sel[SRC_FALL_BIT] ? raw_b : raw_a;
    end
endmodule

// File: rtl/dbgen_hold_delay.sv
// Edge-hold delay lane. Counts enabled clock edges for which the active
// level has been present. The active level is high for a rising-edge lane.
// With IDLE_HIGH set, the lane works on an inverted copy of the input,
// which turns it into a falling-edge delay that uses the same counter.
// Assumes the delay count may change at any time. A change takes effect at
// once against the elapsed time already counted.
module dbgen_hold_delay #(
    parameter int CNT_W     = 10,
    parameter bit IDLE_HIGH = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             din,
    input  logic [CNT_W-1:0] dly,
    output logic             dout
);
    localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

    logic             lvl;
    logic [CNT_W-1:0] run_q;
    logic             held;

    // Map the input onto the active level counted by this lane.
    generate
        if (IDLE_HIGH) begin : g_fall
            assign lvl  = ~din;
            assign dout = ~held;
        end else begin : g_rise
            assign lvl  = din;
            assign dout = held;
        end
    endgenerate

    // Elapsed-time counter: clears on level loss, advances on enabled ticks, saturates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!lvl) begin
            run_q <= '0;
        end else if (tick_en && (run_q != RUN_MAX)) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Release the active level only once the count is reached.
    assign held = lvl && (run_q >= dly);
endmodule

// File: rtl/dbgen_out_stage.sv
// Output stage: for each output, picks the raw input or its delayed lane.
// Polarity inversion applies only where the delayed lane is selected.
// Purely combinational; assumes a later stage registers the drive outputs.
module dbgen_out_stage
    import dbgen_pkg::*;
(
    input  logic       raw_a,
    input  logic       raw_b,
    input  logic       rise_q,
    input  logic       fall_q,
    input  logic [1:0] out_sel,
    input  logic [1:0] pol_sel,
    output logic       out_a,
    output logic       out_b
);
    logic [NUM_LANES-1:0] raw_v;
    logic [NUM_LANES-1:0] dly_v;
    logic [NUM_LANES-1:0] use_dly;
    logic [NUM_LANES-1:0] inv;
    logic [NUM_LANES-1:0] drv;

    // Gather per-output operands into lane vectors (index 0 = A, 1 = B).
    always_comb begin
        raw_v   = {raw_b, raw_a};
        dly_v   = {fall_q, rise_q};
        use_dly = {out_sel[OUT_B_BIT], out_sel[OUT_A_BIT]};
        inv     = {pol_sel[POL_B_BIT], pol_sel[POL_A_BIT]};
    end

    // One identical bypass/polarity switch per output.
    generate
        for (genvar i = 0; i < NUM_LANES; i++) begin : g_out
            assign drv[i] = use_dly[i] ? flip_if(dly_v[i], inv[i]) : raw_v[i];
        end
    endgenerate

    assign out_a = drv[0];
    assign out_b = drv[1];
endmodule

// File: rtl/dbgen_deadband.sv
// Top of the dead-band generator: source router, one rising-edge lane,
// one falling-edge lane and the bypass/polarity output stage.
// Assumes raw_a/raw_b and every select are synchronous to clk.
module dbgen_deadband
    import dbgen_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             raw_a,
    input  logic             raw_b,
    input  logic [CNT_W-1:0] rise_cnt,
    input  logic [CNT_W-1:0] fall_cnt,
    input  logic [1:0]       src_sel,
    input  logic [1:0]       out_sel,
    input  logic [1:0]       pol_sel,
    output logic             out_a,
    output logic             out_b
);
    logic                 rise_src;
    logic                 fall_src;
    logic [NUM_LANES-1:0] lane_in;
    logic [NUM_LANES-1:0] lane_out;
    logic [CNT_W-1:0]     lane_dly [NUM_LANES];
    logic                 rise_q;
    logic                 fall_q;

    dbgen_src_mux u_src (
        .raw_a    (raw_a),
        .raw_b    (raw_b),
        .src_sel  (src_sel),
        .rise_src (rise_src),
        .fall_src (fall_src)
    );

    // Bundle lane operands so both delay lanes come from one loop.
    always_comb begin
        lane_in     = {fall_src, rise_src};
        lane_dly[0] = rise_cnt;
        lane_dly[1] = fall_cnt;
    end

    generate
        for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
            dbgen_hold_delay #(
                .CNT_W     (CNT_W),
                .IDLE_HIGH (i == 1)
            ) u_dly (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick_en (tick_en),
                .din     (lane_in[i]),
                .dly     (lane_dly[i]),
                .dout    (lane_out[i])
            );
        end
    endgenerate

    assign rise_q = lane_out[0];
    assign fall_q = lane_out[1];

    dbgen_out_stage u_out (
        .raw_a   (raw_a),
        .raw_b   (raw_b),
        .rise_q  (rise_q),
        .fall_q  (fall_q),
        .out_sel (out_sel),
        .pol_sel (pol_sel),
        .out_a   (out_a),
        .out_b   (out_b)
    );
endmodule

// File: rtl/dbgen_deadband_chk.sv
// Property checker for the dead-band generator, bound into the top.
// Watches the routed lane inputs and the lane outputs across module edges.
module dbgen_deadband_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             raw_a,
    input logic             raw_b,
    input logic [CNT_W-1:0] rise_cnt,
    input logic [CNT_W-1:0] fall_cnt,
    input logic [1:0]       out_sel,
    input logic             rise_src,
    input logic             fall_src,
    input logic             rise_q,
    input logic             fall_q,
    input logic             out_a,
    input logic             out_b
);
    a_r1_bypass_passes_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 2'b00) |-> (out_a == raw_a && out_b == raw_b));

    a_r5_rise_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |-> rise_src);

    a_r5_rise_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_cnt != '0 && !$past(rise_src)) |-> !rise_q);

    a_r6_fall_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_q |-> !fall_src);

    a_r6_fall_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_cnt != '0 && $past(fall_src)) |-> fall_q);

    a_r8_zero_is_wire: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_cnt == '0) |-> (rise_q == rise_src));
endmodule

bind dbgen_deadband dbgen_deadband_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_a    (raw_a),
    .raw_b    (raw_b),
    .rise_cnt (rise_cnt),
    .fall_cnt (fall_cnt),
    .out_sel  (out_sel),
    .rise_src (rise_src),
    .fall_src (fall_src),
    .rise_q   (rise_q),
    .fall_q   (fall_q),
    .out_a    (out_a),
    .out_b    (out_b)
);

// File: tb/dbgen_deadband_tb.sv
module dbgen_deadband_tb;
    localparam int W   = 3;
    localparam int CAP = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b1;
    logic         raw_a = 1'b0;
    logic         raw_b = 1'b0;
    logic [W-1:0] rise_cnt = '0;
    logic [W-1:0] fall_cnt = '0;
    logic [1:0]   src_sel = 2'b00;
    logic [1:0]   out_sel = 2'b00;
    logic [1:0]   pol_sel = 2'b00;
    logic         out_a;
    logic         out_b;

    int n_chk = 0;
    int n_bad = 0;
    int hi_a = 0, lo_a = 0, hi_b = 0, lo_b = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    dbgen_deadband #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .raw_a(raw_a), .raw_b(raw_b),
        .rise_cnt(rise_cnt), .fall_cnt(fall_cnt),
        .src_sel(src_sel), .out_sel(out_sel), .pol_sel(pol_sel),
        .out_a(out_a), .out_b(out_b)
    );

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%b exp=%b t=%0t src=%b out=%b pol=%b rc=%0d fc=%0d",
                     tag, what, act, exp, $time, src_sel, out_sel, pol_sel, rise_cnt, fall_cnt);
        end
    endtask

    function automatic int nxt(input int run, input logic lvl, input logic en, input logic r);
        if (!r || !lvl) return 0;
        if (en && run < CAP) return run + 1;
        return run;
    endfunction

    function automatic string tag_a();
        if (out_sel == 2'b00) return "R1";
        if (!out_sel[1]) return "R2";
        if (rise_cnt == 0) return "R8";
        if (pol_sel[0]) return "R4";
        if (src_sel[0]) return "R3";
        return "R5";
    endfunction

    function automatic string tag_b();
        if (out_sel == 2'b00) return "R1";
        if (!out_sel[0]) return "R2";
        if (fall_cnt == 0) return "R8";
        if (pol_sel[1]) return "R4";
        if (src_sel[1]) return "R3";
        return "R6";
    endfunction

    // One cycle: drive at negedge, check, then advance the elapsed-time model.
    task automatic step(input logic a, input logic b, input logic e, input logic r, input string tg);
        logic rs, fs, red, fed, ea, eb;
        int rhi, flo;
        @(negedge clk);
        raw_a = a; raw_b = b; tick_en = e; rst_n = r;
        #1;
        rs  = src_sel[0] ? b : a;
        rhi = src_sel[0] ? hi_b : hi_a;
        fs  = src_sel[1] ? b : a;
        flo = src_sel[1] ? lo_b : lo_a;
        red = rs && (rhi >= int'(rise_cnt));
        fed = !(!fs && (flo >= int'(fall_cnt)));
        ea  = out_sel[1] ? (red ^ pol_sel[0]) : a;
        eb  = out_sel[0] ? (fed ^ pol_sel[1]) : b;
        chk((tg == "") ? tag_a() : tg, out_a, ea, "out_a");
        chk((tg == "") ? tag_b() : tg, out_b, eb, "out_b");
        @(posedge clk);
        hi_a = nxt(hi_a, a, e, r);  lo_a = nxt(lo_a, !a, e, r);
        hi_b = nxt(hi_b, b, e, r);  lo_b = nxt(lo_b, !b, e, r);
    endtask

    task automatic cfg(input logic [1:0] s, input logic [1:0] o, input logic [1:0] p,
                       input int rc, input int fc);
        src_sel = s; out_sel = o; pol_sel = p;
        rise_cnt = W'(rc); fall_cnt = W'(fc);
    endtask

    task automatic burst(input logic a, input int n, input logic e, input string tg);
        for (int i = 0; i < n; i++) step(a, raw_b, e, 1'b1, tg);
    endtask

    initial begin : wdog
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int rcs[4];
        int fcs[3];
        logic na, nb;
        rcs = '{0, 1, 3, 7};
        fcs = '{0, 2, 5};

        // R11: reset holds nonzero-count lanes idle (A low, B high)
        cfg(2'b00, 2'b11, 2'b00, 5, 5);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R11");

        // Sweep every select code against several counts and random waveforms
        for (int s = 0; s < 4; s++)
            for (int o = 0; o < 4; o++)
                for (int p = 0; p < 4; p++)
                    for (int ri = 0; ri < 4; ri++)
                        for (int fi = 0; fi < 3; fi++) begin
                            cfg(2'(s), 2'(o), 2'(p), rcs[ri], fcs[fi]);
                            for (int k = 0; k < 24; k++) begin
                                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                                na = (lfsr[2:0] < 3'd2) ? ~raw_a : raw_a;
                                nb = (lfsr[5:3] < 3'd2) ? ~raw_b : raw_b;
                                step(na, nb, (lfsr[9:6] != 4'd0), 1'b1, "");
                            end
                        end

        // R7: pulses of exactly N are swallowed, N+1 shows for one cycle
        cfg(2'b00, 2'b11, 2'b00, 3, 3);
        burst(1'b0, 4, 1'b1, "R7");
        burst(1'b1, 3, 1'b1, "R7");
        burst(1'b0, 4, 1'b1, "R7");
        burst(1'b1, 4, 1'b1, "R7");
        burst(1'b0, 2, 1'b1, "R7");

        // R6: falling delay on B from source A, complementary polarity
        cfg(2'b00, 2'b01, 2'b10, 0, 4);
        burst(1'b1, 3, 1'b1, "R6");
        burst(1'b0, 6, 1'b1, "R6");
        burst(1'b1, 2, 1'b1, "R6");

        // R9: disabled ticks do not advance; a drop still restarts
        cfg(2'b00, 2'b10, 2'b00, 3, 0);
        burst(1'b0, 2, 1'b1, "R9");
        burst(1'b1, 5, 1'b0, "R9");
        burst(1'b1, 4, 1'b1, "R9");
        burst(1'b0, 1, 1'b0, "R9");
        burst(1'b1, 2, 1'b1, "R9");

        // R10: largest count is reachable and holds while the source holds
        cfg(2'b00, 2'b10, 2'b00, CAP, 0);
        burst(1'b0, 2, 1'b1, "R10");
        burst(1'b1, 14, 1'b1, "R10");

        // R11: reset mid-run clears elapsed time
        cfg(2'b00, 2'b10, 2'b00, 2, 0);
        burst(1'b1, 3, 1'b1, "R11");
        step(1'b1, raw_b, 1'b1, 1'b0, "R11");
        burst(1'b1, 3, 1'b1, "R11");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule